// File: doc/BRIEF.md
# Core Idle Power-State Controller

This block manages the idle power state of one processor core. Software offers a deepest acceptable idle depth. Each hardware thread of the core reports whether it is idle. When every thread is idle, the controller chooses a granted depth and moves the core into it. The granted depth is the shallowest of several caps:

- the software request,
- a latency ceiling,
- a deep-state disable switch,
- an imminent-interrupt hint,
- a predictor that counts recent wake-ups.

The controller drives plain control pins for the rest of the core: execution enable, clock stop, PLL enable, power gate and a cache-flush request. It also reports the state whose controls are in force.

Entry to the deepest state takes two steps. The core first halts with its clock running and raises a flush request. It stays there until the cache logic answers with a done level. Only after that is the power gate applied.

A wake event is either an interrupt or any thread leaving idle. A wake event starts an exit sequence of fixed length for the state being left. The same event aborts a flush that has not finished.

The flush pair is a level handshake. The request stays high until done is sampled high or a wake event aborts the entry. Done has no effect at any other time. All other pins are plain levels sampled on every rising clock edge.

Top module: `core_idle_ctrl`

## Requirements
- R1: The core leaves C0 only on a clock edge where every bit of `thread_idle` is 1 and `wake_irq` is 0. Otherwise it stays in C0 whatever depth is requested.
- R2: States use the 2-bit encoding C0=00, C1=01, C3=10, C6=11, and each state drives its own controls:
  - C0: `run_en`=1, `clk_stop`=0, `pll_en`=1, `pwr_off`=0.
  - C1: `run_en`=0, `clk_stop`=0, `pll_en`=1, `pwr_off`=0.
  - C3: `run_en`=0, `clk_stop`=1, `pll_en`=0, `pwr_off`=0.
  - C6: `run_en`=0, `clk_stop`=1, `pll_en`=0, `pwr_off`=1.
  Reset leaves the core in C0.
- R3: The granted depth never exceeds `req_depth` or `lat_cap`, with both compared under the R2 encoding. A request of 00 keeps the core in C0.
- R4: A C6 grant first shows C1 with `flush_req`=1. The request holds until `flush_done` is sampled 1, and on that edge the state becomes C6 with `pwr_off`=1 and `flush_req`=0.
- R5: While `deep_disable` is 1, the grant is at most C3 and no flush is requested.
- R6: While `irq_imminent` is 1, the grant is at most C1.
- R7: Wakes are counted within a window of ACT_WIN cycles that starts at reset. Once ACT_THRESH of them have occurred in the current window, the grant is capped at C1. The count clears at the end of each window.
- R8: Let the wake event be sampled on edge E. The core returns to C0 on edge E+1 when leaving C1, on edge E+8 when leaving C3, and on edge E+32 when leaving C6. Until then it reports the state being left.
- R9: During an exit, `pwr_off` is 0 and `pll_en` is 1 from edge E onward. When leaving C3 or C6, `clk_stop` stays 1 until the return to C0.
- R10: A wake event during a pending flush drops `flush_req` on the edge that samples it. The core returns to C0 one edge later.
- R11: A wake event is `wake_irq`=1 or any `thread_idle` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thread_idle | input | NTHREADS | Per-thread idle flags, 1 = idle |
| req_depth | input | 2 | Deepest state software accepts |
| lat_cap | input | 2 | Deepest state the latency budget allows |
| deep_disable | input | 1 | Caps the grant at C3 |
| irq_imminent | input | 1 | Interrupt expected soon; caps the grant at C1 |
| wake_irq | input | 1 | Interrupt arrival, a wake event |
| flush_done | input | 1 | Cache flush finished |
| cur_state | output | 2 | State whose controls are applied |
| run_en | output | 1 | Instruction execution allowed |
| clk_stop | output | 1 | Core clock stopped |
| pll_en | output | 1 | PLL enabled |
| pwr_off | output | 1 | Core power gate applied |
| flush_req | output | 1 | Cache flush request |

## Verification
The bench builds the block with two threads, exit latencies of 1, 8 and 32 cycles, a 64-cycle predictor window and a threshold of three wakes. Two threads are enough to show that a single busy thread blocks entry. The short window lets the bench do three wakes right after reset, see the grant capped at C1, then let the window expire and see a full C6 entry come back. The 32-cycle C6 exit is short enough to check on both sides of its expiry edge.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

  typedef enum logic [1:0] {
    CS_C0 = 2'b00,
    CS_C1 = 2'b01,
    CS_C3 = 2'b10,
    CS_C6 = 2'b11
  } cstate_e;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_FLUSH = 2'd1,
    PH_RES   = 2'd2,
    PH_EXIT  = 2'd3
  } phase_e;

  function automatic cstate_e shallower(cstate_e a, cstate_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/cidle_grant.sv
module cidle_grant
  import cidle_pkg::*;
(
  input  logic [1:0] req_depth,
  input  logic [1:0] lat_cap,
  input  logic       deep_disable,
  input  logic       irq_imminent,
  input  logic       pred_hot,
  output cstate_e    grant
);

  cstate_e cap_sw, cap_deep, cap_soon;

  always_comb begin
    cap_sw   = shallower(cstate_e'(req_depth), cstate_e'(lat_cap));
    cap_deep = deep_disable ? CS_C3 : CS_C6;
    cap_soon = (irq_imminent || pred_hot) ? CS_C1 : CS_C6;
    grant    = shallower(cap_sw, shallower(cap_deep, cap_soon));
  end

endmodule

// File: rtl/cidle_predict.sv
module cidle_predict #(
  parameter int ACT_WIN    = 64,
  parameter int ACT_THRESH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_pulse,
  output logic pred_hot
);

  localparam int WW = (ACT_WIN > 1) ? $clog2(ACT_WIN) : 1;
  localparam int TW = $clog2(ACT_THRESH + 1);

  logic [WW-1:0] win_q;
  logic [TW-1:0] cnt_q;
  logic          win_end;

  assign win_end  = (win_q == WW'(ACT_WIN - 1));
  assign pred_hot = (cnt_q >= TW'(ACT_THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_end ? '0 : win_q + 1'b1;
      if (win_end)
        cnt_q <= '0;
      else if (wake_pulse && !pred_hot)
        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
  import cidle_pkg::*;
#(
  parameter int NTHREADS = 2,
  parameter int LAT_C1   = 1,
  parameter int LAT_C3   = 8,
  parameter int LAT_C6   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHREADS-1:0] thread_idle,
  input  logic                wake_irq,
  input  logic                flush_done,
  input  cstate_e             grant,
  output cstate_e             cur,
  output logic                wake_pulse,
  output logic                run_en,
  output logic                clk_stop,
  output logic                pll_en,
  output logic                pwr_off,
  output logic                flush_req
);

  localparam int CW = $clog2(LAT_C6 + 1);

  phase_e        phase_q;
  cstate_e       cur_q;
  logic [CW-1:0] cnt_q;
  logic          all_idle, wake_evt;

  assign all_idle   = &thread_idle;
  assign wake_evt   = wake_irq || !all_idle;
  assign wake_pulse = wake_evt && (phase_q == PH_RES || phase_q == PH_FLUSH);
  assign cur        = cur_q;

  function automatic logic [CW-1:0] exit_load(cstate_e s);
    case (s)
      CS_C3:   return CW'(LAT_C3 - 1);
      CS_C6:   return CW'(LAT_C6 - 1);
      default: return CW'(LAT_C1 - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cur_q   <= CS_C0;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_RUN: begin
          if (all_idle && !wake_irq && grant != CS_C0) begin
            if (grant == CS_C6) begin
              phase_q <= PH_FLUSH;
              cur_q   <= CS_C1;
            end else begin
              phase_q <= PH_RES;
              cur_q   <= grant;
            end
          end
        end
        PH_FLUSH: begin
          if (wake_evt) begin
            phase_q <= PH_EXIT;
            cnt_q   <= exit_load(CS_C1);
          end else if (flush_done) begin
            phase_q <= PH_RES;
            cur_q   <= CS_C6;
          end
        end
        PH_RES: begin
          if (wake_evt) begin
            phase_q <= PH_EXIT;
            cnt_q   <= exit_load(cur_q);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            phase_q <= PH_RUN;
            cur_q   <= CS_C0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    run_en    = 1'b0;
    clk_stop  = 1'b0;
    pll_en    = 1'b1;
    pwr_off   = 1'b0;
    flush_req = 1'b0;
    case (phase_q)
      PH_RUN:   run_en = 1'b1;
      PH_FLUSH: flush_req = 1'b1;
      PH_RES: begin
        clk_stop = (cur_q != CS_C1);
        pll_en   = (cur_q == CS_C1);
        pwr_off  = (cur_q == CS_C6);
      end
      default:  clk_stop = (cur_q != CS_C1);
    endcase
  end

endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import cidle_pkg::*;
#(
  parameter int NTHREADS   = 2,
  parameter int LAT_C1     = 1,
  parameter int LAT_C3     = 8,
  parameter int LAT_C6     = 32,
  parameter int ACT_WIN    = 64,
  parameter int ACT_THRESH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHREADS-1:0] thread_idle,
  input  logic [1:0]          req_depth,
  input  logic [1:0]          lat_cap,
  input  logic                deep_disable,
  input  logic                irq_imminent,
  input  logic                wake_irq,
  input  logic                flush_done,
  output logic [1:0]          cur_state,
  output logic                run_en,
  output logic                clk_stop,
  output logic                pll_en,
  output logic                pwr_off,
  output logic                flush_req
);

  cstate_e grant, cur;
  logic    pred_hot, wake_pulse;

  cidle_grant u_grant (
    .req_depth    (req_depth),
    .lat_cap      (lat_cap),
    .deep_disable (deep_disable),
    .irq_imminent (irq_imminent),
    .pred_hot     (pred_hot),
    .grant        (grant)
  );

  cidle_predict #(
    .ACT_WIN    (ACT_WIN),
    .ACT_THRESH (ACT_THRESH)
  ) u_pred (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_pulse (wake_pulse),
    .pred_hot   (pred_hot)
  );

  cidle_seq #(
    .NTHREADS (NTHREADS),
    .LAT_C1   (LAT_C1),
    .LAT_C3   (LAT_C3),
    .LAT_C6   (LAT_C6)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .thread_idle (thread_idle),
    .wake_irq    (wake_irq),
    .flush_done  (flush_done),
    .grant       (grant),
    .cur         (cur),
    .wake_pulse  (wake_pulse),
    .run_en      (run_en),
    .clk_stop    (clk_stop),
    .pll_en      (pll_en),
    .pwr_off     (pwr_off),
    .flush_req   (flush_req)
  );

  assign cur_state = cur;

endmodule

// File: rtl/core_idle_chk.sv
module core_idle_chk #(
  parameter int NTHREADS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NTHREADS-1:0] thread_idle,
  input logic [1:0]          req_depth,
  input logic                deep_disable,
  input logic                irq_imminent,
  input logic                wake_irq,
  input logic                flush_done,
  input logic [1:0]          cur_state,
  input logic                pwr_off,
  input logic                flush_req
);

  a_r1_leave_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_state) == 2'b00 && cur_state != 2'b00) |-> ($past(&thread_idle) && !$past(wake_irq)));

  a_r3_req_is_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_state) == 2'b00 && cur_state != 2'b00) |-> (cur_state <= $past(req_depth)));

  a_r4_flush_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> ($past(flush_req) && $past(flush_done)));

  a_r4_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done && (&thread_idle) && !wake_irq) |=> flush_req);

  a_r5_no_flush_when_capped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> !$past(deep_disable));

  a_r6_imminent_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_state) == 2'b00 && cur_state != 2'b00 && $past(irq_imminent)) |-> (cur_state == 2'b01));

endmodule

bind core_idle_ctrl core_idle_chk #(.NTHREADS(NTHREADS)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thread_idle  (thread_idle),
  .req_depth    (req_depth),
  .deep_disable (deep_disable),
  .irq_imminent (irq_imminent),
  .wake_irq     (wake_irq),
  .flush_done   (flush_done),
  .cur_state    (cur_state),
  .pwr_off      (pwr_off),
  .flush_req    (flush_req)
);

// File: tb/test_core_idle_ctrl.sv
module test_core_idle_ctrl;

  localparam int PERIOD = 10;
  localparam int NT     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] thread_idle = '0;
  logic [1:0]    req_depth = 2'b00;
  logic [1:0]    lat_cap = 2'b11;
  logic          deep_disable = 1'b0;
  logic          irq_imminent = 1'b0;
  logic          wake_irq = 1'b0;
  logic          flush_done = 1'b0;
  logic [1:0]    cur_state;
  logic          run_en, clk_stop, pll_en, pwr_off, flush_req;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  core_idle_ctrl #(
    .NTHREADS(NT), .LAT_C1(1), .LAT_C3(8), .LAT_C6(32), .ACT_WIN(64), .ACT_THRESH(3)
  ) i_core_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .thread_idle(thread_idle), .req_depth(req_depth),
    .lat_cap(lat_cap), .deep_disable(deep_disable), .irq_imminent(irq_imminent),
    .wake_irq(wake_irq), .flush_done(flush_done), .cur_state(cur_state),
    .run_en(run_en), .clk_stop(clk_stop), .pll_en(pll_en), .pwr_off(pwr_off),
    .flush_req(flush_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    thread_idle = '0; req_depth = 2'b00; lat_cap = 2'b11;
    deep_disable = 1'b0; irq_imminent = 1'b0; wake_irq = 1'b0; flush_done = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset state", cur_state, 0);
    chk("R2 reset run_en", run_en, 1);
    chk("R2 reset clk_stop", clk_stop, 0);
    chk("R2 reset pll_en", pll_en, 1);
    chk("R2 reset pwr_off", pwr_off, 0);
    chk("R2 reset flush_req", flush_req, 0);
  endtask

  task automatic t_one_busy();
    do_reset();
    req_depth = 2'b11; thread_idle = 2'b01;
    tick(3);
    chk("R1 one thread busy keeps C0", cur_state, 0);
    thread_idle = 2'b11; wake_irq = 1'b1;
    tick(3);
    chk("R1 wake_irq keeps C0", cur_state, 0);
    wake_irq = 1'b0; thread_idle = '0;
  endtask

  task automatic t_c1();
    do_reset();
    req_depth = 2'b01; thread_idle = '1;
    tick(1);
    chk("R2 C1 state", cur_state, 1);
    chk("R2 C1 run_en", run_en, 0);
    chk("R2 C1 clock runs", clk_stop, 0);
    wake_irq = 1'b1;
    tick(1);
    chk("R8 C1 exit not yet", cur_state, 1);
    tick(1);
    chk("R11 irq wakes C1", cur_state, 0);
    chk("R8 C1 run_en back", run_en, 1);
    wake_irq = 1'b0; thread_idle = '0;
  endtask

  task automatic t_c3();
    do_reset();
    req_depth = 2'b10; thread_idle = '1;
    tick(1);
    chk("R2 C3 state", cur_state, 2);
    chk("R2 C3 clk_stop", clk_stop, 1);
    chk("R2 C3 pll off", pll_en, 0);
    thread_idle = 2'b10;
    tick(1);
    chk("R9 C3 exit pll on", pll_en, 1);
    chk("R9 C3 exit clock stopped", clk_stop, 1);
    tick(7);
    chk("R8 C3 still exiting at E+7", cur_state, 2);
    tick(1);
    chk("R8 C3 back at E+8", cur_state, 0);
    thread_idle = '0;
  endtask

  task automatic t_c6();
    do_reset();
    req_depth = 2'b11; thread_idle = '1;
    tick(1);
    chk("R4 flush shows C1", cur_state, 1);
    chk("R4 flush_req up", flush_req, 1);
    tick(3);
    chk("R4 flush_req held", flush_req, 1);
    chk("R4 no power gate yet", pwr_off, 0);
    flush_done = 1'b1;
    tick(1);
    flush_done = 1'b0;
    chk("R4 C6 state", cur_state, 3);
    chk("R2 C6 pwr_off", pwr_off, 1);
    chk("R4 flush_req dropped", flush_req, 0);
    thread_idle = '0;
    tick(1);
    chk("R9 C6 exit power back", pwr_off, 0);
    chk("R9 C6 exit clock stopped", clk_stop, 1);
    tick(31);
    chk("R8 C6 still exiting at E+31", cur_state, 3);
    tick(1);
    chk("R8 C6 back at E+32", cur_state, 0);
  endtask

  task automatic t_abort();
    do_reset();
    req_depth = 2'b11; thread_idle = '1;
    tick(3);
    chk("R4 pending flush", flush_req, 1);
    wake_irq = 1'b1;
    tick(1);
    chk("R10 abort drops flush_req", flush_req, 0);
    tick(1);
    chk("R10 abort back to C0", cur_state, 0);
    wake_irq = 1'b0; thread_idle = '0;
  endtask

  task automatic t_caps();
    do_reset();
    req_depth = 2'b11; deep_disable = 1'b1; thread_idle = '1;
    tick(1);
    chk("R5 deep_disable caps at C3", cur_state, 2);
    chk("R5 no flush", flush_req, 0);
    thread_idle = '0; tick(10); deep_disable = 1'b0;
    lat_cap = 2'b01; thread_idle = '1;
    tick(1);
    chk("R3 lat_cap caps at C1", cur_state, 1);
    thread_idle = '0; tick(2); lat_cap = 2'b11;
    irq_imminent = 1'b1; thread_idle = '1;
    tick(1);
    chk("R6 irq_imminent caps at C1", cur_state, 1);
    thread_idle = '0; tick(2); irq_imminent = 1'b0;
    req_depth = 2'b00; thread_idle = '1;
    tick(3);
    chk("R3 request C0 stays active", cur_state, 0);
    thread_idle = '0;
  endtask

  task automatic t_predict();
    do_reset();
    req_depth = 2'b01;
    for (int i = 0; i < 3; i++) begin
      thread_idle = '1; tick(1);
      thread_idle = '0; tick(2);
    end
    req_depth = 2'b11; thread_idle = '1;
    tick(1);
    chk("R7 busy history caps at C1", cur_state, 1);
    chk("R7 no flush while capped", flush_req, 0);
    thread_idle = '0;
    tick(140);
    thread_idle = '1;
    tick(1);
    chk("R7 window cleared allows C6 entry", flush_req, 1);
    thread_idle = '0;
    tick(2);
  endtask

  initial begin
    t_reset();
    t_one_busy();
    t_c1();
    t_c3();
    t_c6();
    t_abort();
    t_caps();
    t_predict();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule